// File: doc/BRIEF.md
# Half-Duplex Collision and Retry Controller

This block decides how a half-duplex transmitter responds when the medium reports a collision. While an attempt is in flight it watches the collision input, the running bit count of the attempt and a flag that says the preamble and start-of-frame delimiter are out. It then tells the transmit path to keep sending, to send the jam pattern, or to go idle. After each jam it either asks an external timer for a backoff and restarts the frame once that timer answers, or it gives the frame up.

When a frame ends, successfully or not, the block raises a one-cycle completion pulse together with the frame's status flags. These say whether one retry or several were needed, whether the retry budget ran out, and whether a late collision was seen. A flush request accompanies every frame that is given up. The collision count that leads to each backoff request is shown on an output, so a random-delay generator can scale its range from it. Serialisation, the random number source and the backoff delay itself live outside this block.

Top module: `coll_retry_top`

## Requirements
- R1: A collision that arrives while `preambleDone` is low keeps `txCmd` at SEND (1) until `preambleDone` is seen high; `txCmd` becomes JAM (2) in the cycle after that.
- R2: A collision that arrives while `preambleDone` is high and `bitCount` is below 512 drives `txCmd` to JAM (2) in the very next cycle.
- R3: Every jam keeps `txCmd` at JAM for exactly 32 consecutive cycles, and `jamBit` is 0 throughout.
- R4: After the jam for a collision that still allows a retry, `backoffReq` pulses for one cycle. At that point `attemptCnt` equals the number of collisions seen so far in the frame. `txCmd` stays IDLE (0) until `backoffDone` is seen, and is SEND (1) in the cycle after.
- R5: A frame gets at most 16 attempts. The jam that follows the 16th collision ends the frame with only `statRtry` set, with `flushReq`, and with no backoff request.
- R6: A frame that ends with `txEnd` and no collision in that cycle completes with no flush. `statOne` alone is set if there was exactly one retry, `statMore` alone if there were two or more, and no status flag if there were none.
- R7: With `noRetry` high, the jam after the first collision ends the frame with only `statRtry` set and with `flushReq`. No backoff is requested.
- R8: A collision seen while `bitCount` is 512 or more is late. After its jam the frame ends with only `statLcol` set and with `flushReq`, and no backoff is requested. A collision at 511 is an ordinary one.
- R9: If `colIn` and `txEnd` are high in the same cycle of an attempt, the collision is taken: the jam starts and no completion is reported.
- R10: `doneValid` lasts exactly one cycle per frame, and the status flags and `flushReq` are 0 outside it. `attemptCnt` holds its value after completion and clears when the next `startReq` is accepted. `startReq` is ignored while a frame is in progress.
- R11: After reset `txCmd` is IDLE (0), `attemptCnt` is 0, and `doneValid`, `backoffReq`, `flushReq` and all status flags are 0.
- R12: `colIn` has no effect while the block waits for the end of the preamble, while it jams, and while it is in backoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin a new frame (accepted only when idle) |
| colIn | input | 1 | Collision reported by the medium |
| bitCount | input | 14 | Bits sent so far in the current attempt |
| preambleDone | input | 1 | Preamble and start delimiter fully sent |
| txEnd | input | 1 | Current attempt finished its last bit |
| noRetry | input | 1 | Configuration: give up on the first collision |
| backoffDone | input | 1 | External backoff delay has elapsed |
| txCmd | output | 2 | 0 IDLE, 1 SEND, 2 JAM |
| jamBit | output | 1 | Jam data bit (valid while txCmd is JAM) |
| backoffReq | output | 1 | One-cycle request to start a backoff delay |
| attemptCnt | output | 5 | Collisions seen in the current frame |
| doneValid | output | 1 | One-cycle frame completion pulse |
| flushReq | output | 1 | Drop the frame from the FIFO (with doneValid) |
| statOne | output | 1 | Exactly one retry was needed |
| statMore | output | 1 | More than one retry was needed |
| statRtry | output | 1 | Retries exhausted or disabled |
| statLcol | output | 1 | Late collision |

## Verification
A collision and the normal end of an attempt can fall in the same cycle. The block must then treat the frame as collided, not completed. The bench raises `colIn` and `txEnd` on the same edge. It checks that JAM follows one cycle later, that no completion pulse appears, and that the frame later finishes with the one-retry status. A second overlap is a collision in the same cycle that the preamble completes. That collision must jam at once, and the bench tests it alongside the delayed-jam case and the 511/512 bit-count boundary.

// File: rtl/cr_pkg.sv
package cr_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_SEND = 2'd1,
    CMD_JAM  = 2'd2
  } txCmd_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_XMIT    = 3'd1,
    ST_WAITPRE = 3'd2,
    ST_JAM     = 3'd3,
    ST_BACKOFF = 3'd4
  } crState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrColl;     // new frame: clear collision count and late flag
    logic incColl;     // collision accepted
    logic captLate;    // latch late-collision decision
    logic clrJam;      // restart jam bit counter
    logic stepJam;     // one jam bit sent
    logic finOk;       // frame completed on the wire
    logic finFlush;    // frame given up
    logic reqBackoff;  // ask for a backoff delay
  } crStrobe_t;

endpackage

// File: rtl/cr_datapath.sv
module cr_datapath
  import cr_pkg::*;
#(
  parameter int MAX_ATTEMPTS = 16,
  parameter int SLOT_BITS    = 512,
  parameter int JAM_BITS     = 32,
  parameter int BITCNT_W     = 14,
  localparam int CNT_W       = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  crStrobe_t           strb,
  input  logic [BITCNT_W-1:0] bitCount,
  output logic                jamLast,
  output logic                lateSeen,
  output logic                attemptsUsed,
  output logic                jamBit,
  output logic                backoffReq,
  output logic [CNT_W-1:0]    attemptCnt,
  output logic                doneValid,
  output logic                flushReq,
  output logic                statOne,
  output logic                statMore,
  output logic                statRtry,
  output logic                statLcol
);

  localparam int JAM_W = (JAM_BITS > 1) ? $clog2(JAM_BITS) : 1;
  localparam logic [JAM_BITS-1:0] JAM_PATTERN = '0;

  logic [CNT_W-1:0] collCnt;
  logic [JAM_W-1:0] jamIdx;
  logic             lateFlag;

  // collision counter and late-collision flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      collCnt  <= '0;
      lateFlag <= 1'b0;
    end else if (strb.clrColl) begin
      collCnt  <= '0;
      lateFlag <= 1'b0;
    end else begin
      if (strb.incColl)  collCnt  <= collCnt + 1'b1;
      if (strb.captLate) lateFlag <= (bitCount >= BITCNT_W'(SLOT_BITS));
    end
  end

  // jam bit counter
  always_ff @(posedge clk) begin
    if (!rstN)             jamIdx <= '0;
    else if (strb.clrJam)  jamIdx <= '0;
    else if (strb.stepJam) jamIdx <= jamIdx + 1'b1;
  end

  assign jamLast      = (jamIdx == JAM_W'(JAM_BITS - 1));
  assign lateSeen     = lateFlag;
  assign attemptsUsed = (collCnt >= CNT_W'(MAX_ATTEMPTS));
  assign jamBit       = JAM_PATTERN[jamIdx];
  assign attemptCnt   = collCnt;

  // completion status, registered into a single-cycle pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid  <= 1'b0;
      flushReq   <= 1'b0;
      statOne    <= 1'b0;
      statMore   <= 1'b0;
      statRtry   <= 1'b0;
      statLcol   <= 1'b0;
      backoffReq <= 1'b0;
    end else begin
      doneValid  <= strb.finOk | strb.finFlush;
      flushReq   <= strb.finFlush;
      statOne    <= strb.finOk & (collCnt == CNT_W'(1));
      statMore   <= strb.finOk & (collCnt > CNT_W'(1));
      statRtry   <= strb.finFlush & ~lateFlag;
      statLcol   <= strb.finFlush & lateFlag;
      backoffReq <= strb.reqBackoff;
    end
  end

  assert_attempt_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    collCnt <= CNT_W'(MAX_ATTEMPTS));

  assert_status_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $onehot0({statOne, statMore, statRtry, statLcol}));

  assert_flush_without_backoff_R8: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> (doneValid && !backoffReq && !statOne && !statMore));

  assert_done_single_cycle_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  assert_status_only_on_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    !doneValid |-> !(statOne || statMore || statRtry || statLcol || flushReq));

endmodule

// File: rtl/cr_ctrl.sv
module cr_ctrl
  import cr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      colIn,
  input  logic      preambleDone,
  input  logic      txEnd,
  input  logic      noRetry,
  input  logic      backoffDone,
  input  logic      jamLast,
  input  logic      lateSeen,
  input  logic      attemptsUsed,
  output crStrobe_t strb,
  output txCmd_e    txCmd
);

  crState_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strb.clrColl = 1'b1;
          stateNxt     = ST_XMIT;
        end
      end
      ST_XMIT: begin
        if (colIn) begin
          // collision takes precedence over a simultaneous end of frame
          strb.incColl  = 1'b1;
          strb.captLate = 1'b1;
          strb.clrJam   = 1'b1;
          stateNxt      = preambleDone ? ST_JAM : ST_WAITPRE;
        end else if (txEnd) begin
          strb.finOk = 1'b1;
          stateNxt   = ST_IDLE;
        end
      end
      ST_WAITPRE: begin
        if (preambleDone) stateNxt = ST_JAM;
      end
      ST_JAM: begin
        strb.stepJam = 1'b1;
        if (jamLast) begin
          if (lateSeen || noRetry || attemptsUsed) begin
            strb.finFlush = 1'b1;
            stateNxt      = ST_IDLE;
          end else begin
            strb.reqBackoff = 1'b1;
            stateNxt        = ST_BACKOFF;
          end
        end
      end
      ST_BACKOFF: begin
        if (backoffDone) stateNxt = ST_XMIT;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_XMIT, ST_WAITPRE: txCmd = CMD_SEND;
      ST_JAM:              txCmd = CMD_JAM;
      default:             txCmd = CMD_IDLE;
    endcase
  end

  assert_pre_sfd_holds_send_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XMIT && colIn && !preambleDone) |=> (txCmd == CMD_SEND));

  assert_jam_immediate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XMIT && colIn && preambleDone) |=> (txCmd == CMD_JAM));

  assert_jam_runs_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_JAM && !jamLast) |=> (txCmd == CMD_JAM));

  assert_backoff_waits_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BACKOFF && !backoffDone) |=> (txCmd == CMD_IDLE));

  assert_collision_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XMIT && colIn && txEnd) |=> (txCmd != CMD_IDLE));

endmodule

// File: rtl/coll_retry_top.sv
module coll_retry_top
  import cr_pkg::*;
#(
  parameter int MAX_ATTEMPTS = 16,
  parameter int SLOT_BITS    = 512,
  parameter int JAM_BITS     = 32,
  parameter int BITCNT_W     = 14
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 startReq,
  input  logic                                 colIn,
  input  logic [BITCNT_W-1:0]                  bitCount,
  input  logic                                 preambleDone,
  input  logic                                 txEnd,
  input  logic                                 noRetry,
  input  logic                                 backoffDone,
  output logic [1:0]                           txCmd,
  output logic                                 jamBit,
  output logic                                 backoffReq,
  output logic [$clog2(MAX_ATTEMPTS+1)-1:0]    attemptCnt,
  output logic                                 doneValid,
  output logic                                 flushReq,
  output logic                                 statOne,
  output logic                                 statMore,
  output logic                                 statRtry,
  output logic                                 statLcol
);

  crStrobe_t strb;
  txCmd_e    cmd;
  logic      jamLast;
  logic      lateSeen;
  logic      attemptsUsed;

  cr_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .colIn        (colIn),
    .preambleDone (preambleDone),
    .txEnd        (txEnd),
    .noRetry      (noRetry),
    .backoffDone  (backoffDone),
    .jamLast      (jamLast),
    .lateSeen     (lateSeen),
    .attemptsUsed (attemptsUsed),
    .strb         (strb),
    .txCmd        (cmd)
  );

  cr_datapath #(
    .MAX_ATTEMPTS (MAX_ATTEMPTS),
    .SLOT_BITS    (SLOT_BITS),
    .JAM_BITS     (JAM_BITS),
    .BITCNT_W     (BITCNT_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .bitCount     (bitCount),
    .jamLast      (jamLast),
    .lateSeen     (lateSeen),
    .attemptsUsed (attemptsUsed),
    .jamBit       (jamBit),
    .backoffReq   (backoffReq),
    .attemptCnt   (attemptCnt),
    .doneValid    (doneValid),
    .flushReq     (flushReq),
    .statOne      (statOne),
    .statMore     (statMore),
    .statRtry     (statRtry),
    .statLcol     (statLcol)
  );

  assign txCmd = cmd;

endmodule

// File: tb/coll_retry_top_tb.sv
`timescale 1ns/1ps
module coll_retry_top_tb_top;

  localparam int CMD_IDLE = 0;
  localparam int CMD_SEND = 1;
  localparam int CMD_JAM  = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        colIn = 1'b0;
  logic [13:0] bitCount = '0;
  logic        preambleDone = 1'b0;
  logic        txEnd = 1'b0;
  logic        noRetry = 1'b0;
  logic        backoffDone = 1'b0;
  logic [1:0]  txCmd;
  logic        jamBit;
  logic        backoffReq;
  logic [4:0]  attemptCnt;
  logic        doneValid;
  logic        flushReq;
  logic        statOne;
  logic        statMore;
  logic        statRtry;
  logic        statLcol;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  coll_retry_top dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .colIn(colIn),
    .bitCount(bitCount), .preambleDone(preambleDone), .txEnd(txEnd),
    .noRetry(noRetry), .backoffDone(backoffDone), .txCmd(txCmd),
    .jamBit(jamBit), .backoffReq(backoffReq), .attemptCnt(attemptCnt),
    .doneValid(doneValid), .flushReq(flushReq), .statOne(statOne),
    .statMore(statMore), .statRtry(statRtry), .statLcol(statLcol)
  );

  typedef struct packed {
    int nColl;  bit late; bit noRet; bit preSfd;
    bit eOne; bit eMore; bit eRtry; bit eLcol; bit eFlush;
    int eBack;
  } vec_t;

  // nColl, late-on-last, noRetry, pre-SFD, one, more, rtry, lcol, flush, backoffs
  localparam vec_t VECS [10] = '{
    '{0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0},
    '{1,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1},
    '{2,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2},
    '{15, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 15},
    '{16, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 15},
    '{1,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 0},
    '{1,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 0},
    '{3,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2},
    '{1,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1},
    '{0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkStatus(input string req, input bit o, input bit m, input bit r,
                             input bit l, input bit f);
    check(doneValid == 1'b1, {req, " doneValid"}, int'(doneValid), 1);
    check({statOne, statMore, statRtry, statLcol, flushReq} == {o, m, r, l, f},
          {req, " status one/more/rtry/lcol/flush"},
          int'({statOne, statMore, statRtry, statLcol, flushReq}), int'({o, m, r, l, f}));
  endtask

  task automatic pulseStart();
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // counts JAM cycles until backoffReq or doneValid shows up
  task automatic countJam(output int n);
    n = 0;
    for (int k = 0; k < 200 && !(backoffReq || doneValid); k++) begin
      if (txCmd == 2'(CMD_JAM)) begin
        n++;
        if (jamBit != 1'b0) check(1'b0, "R3 jamBit", int'(jamBit), 0);
      end
      @(negedge clk);
    end
  endtask

  task automatic giveBackoff();
    @(negedge clk);
    backoffDone = 1'b1;
    @(negedge clk);
    backoffDone = 1'b0;
  endtask

  task automatic runVector(input vec_t v, input int idx);
    int coll = 0;
    int backs = 0;
    int jamN;
    bit fin = 1'b0;
    noRetry = v.noRet;
    preambleDone = 1'b0;
    pulseStart();
    check(attemptCnt == 5'd0, "R10 attemptCnt cleared at start", int'(attemptCnt), 0);
    while (!fin) begin
      repeat (2) @(negedge clk);
      if (coll < v.nColl) begin
        coll++;
        bitCount = (v.late && coll == v.nColl) ? 14'd700 : 14'd100;
        preambleDone = !v.preSfd;
        colIn = 1'b1;
        @(negedge clk);
        colIn = 1'b0;
        if (v.preSfd) begin
          repeat (3) @(negedge clk);
          preambleDone = 1'b1;
          @(negedge clk);
        end
        countJam(jamN);
        check(jamN == 32, $sformatf("R3 jam length vec %0d", idx), jamN, 32);
        if (backoffReq) begin
          backs++;
          check(attemptCnt == 5'(coll), "R4 attemptCnt at backoff", int'(attemptCnt), coll);
          giveBackoff();
          check(txCmd == 2'(CMD_SEND), "R4 resend after backoff", int'(txCmd), CMD_SEND);
        end else begin
          fin = 1'b1;
        end
      end else begin
        txEnd = 1'b1;
        @(negedge clk);
        txEnd = 1'b0;
        fin = 1'b1;
      end
    end
    checkStatus($sformatf("R5/R6/R7/R8 vec %0d", idx), v.eOne, v.eMore, v.eRtry, v.eLcol, v.eFlush);
    check(backs == v.eBack, $sformatf("R4/R5 backoff count vec %0d", idx), backs, v.eBack);
    @(negedge clk);
    check(doneValid == 1'b0, "R10 done single cycle", int'(doneValid), 0);
    check(attemptCnt == 5'(coll), "R10 attemptCnt held after done", int'(attemptCnt), coll);
    bitCount = '0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int jamN;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check(txCmd == 2'(CMD_IDLE), "R11 txCmd after reset", int'(txCmd), CMD_IDLE);
    check({doneValid, backoffReq, flushReq, statOne, statMore, statRtry, statLcol} == 7'd0,
          "R11 outputs after reset",
          int'({doneValid, backoffReq, flushReq, statOne, statMore, statRtry, statLcol}), 0);
    check(attemptCnt == 5'd0, "R11 attemptCnt after reset", int'(attemptCnt), 0);

    for (int i = 0; i < 10; i++) runVector(VECS[i], i);

    // R9: collision and end of frame in the same cycle
    noRetry = 1'b0;
    preambleDone = 1'b1;
    bitCount = 14'd200;
    pulseStart();
    @(negedge clk);
    colIn = 1'b1;
    txEnd = 1'b1;
    @(negedge clk);
    colIn = 1'b0;
    txEnd = 1'b0;
    check(txCmd == 2'(CMD_JAM), "R9 jam wins", int'(txCmd), CMD_JAM);
    check(doneValid == 1'b0, "R9 no completion", int'(doneValid), 0);
    // R12: collision during jam ignored; R10: start ignored while busy
    colIn = 1'b1;
    startReq = 1'b1;
    @(negedge clk);
    colIn = 1'b0;
    startReq = 1'b0;
    check(attemptCnt == 5'd1, "R12 collision in jam ignored", int'(attemptCnt), 1);
    countJam(jamN);
    check(backoffReq == 1'b1, "R9 backoff after jam", int'(backoffReq), 1);
    @(negedge clk);
    colIn = 1'b1;
    @(negedge clk);
    colIn = 1'b0;
    check(txCmd == 2'(CMD_IDLE) && attemptCnt == 5'd1, "R12 collision in backoff ignored",
          int'(attemptCnt), 1);
    giveBackoff();
    txEnd = 1'b1;
    @(negedge clk);
    txEnd = 1'b0;
    checkStatus("R9 one retry after overlap", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);

    // R1/R12: pre-SFD collision holds SEND, extra collision ignored
    preambleDone = 1'b0;
    bitCount = 14'd20;
    pulseStart();
    colIn = 1'b1;
    @(negedge clk);
    check(txCmd == 2'(CMD_SEND), "R1 send during preamble", int'(txCmd), CMD_SEND);
    repeat (4) @(negedge clk);
    check(txCmd == 2'(CMD_SEND), "R1 still send before preambleDone", int'(txCmd), CMD_SEND);
    colIn = 1'b0;
    check(attemptCnt == 5'd1, "R12 collision while waiting preamble ignored", int'(attemptCnt), 1);
    preambleDone = 1'b1;
    @(negedge clk);
    check(txCmd == 2'(CMD_JAM), "R1 jam after preamble", int'(txCmd), CMD_JAM);
    countJam(jamN);
    check(jamN == 32, "R3 jam length after preamble", jamN, 32);
    giveBackoff();

    // R2/R8 boundary: 511 is normal, R2 jam next cycle
    bitCount = 14'd511;
    colIn = 1'b1;
    @(negedge clk);
    colIn = 1'b0;
    check(txCmd == 2'(CMD_JAM), "R2 jam next cycle", int'(txCmd), CMD_JAM);
    countJam(jamN);
    check(backoffReq == 1'b1 && doneValid == 1'b0, "R8 511 not late", int'(backoffReq), 1);
    giveBackoff();
    // 512 is late
    bitCount = 14'd512;
    colIn = 1'b1;
    @(negedge clk);
    colIn = 1'b0;
    countJam(jamN);
    checkStatus("R8 512 late", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    check(backoffReq == 1'b0, "R8 no backoff on late", int'(backoffReq), 0);
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule